// File: doc/BRIEF.md
# Indexed Addressing Bus Sequencer

This block drives the bus during the operand phase of an 8-bit processor instruction. The opcode fetch and decode stay outside the block. Once decode has picked an addressing mode and an operation class, the block gets a start pulse and the address of the first operand byte. It then places one address per clock on a 16-bit bus, with a read/write strobe, until the operand access is complete.

The modes are immediate, zero page, zero page indexed by X or Y, absolute, absolute indexed by X or Y, indirect with X added before the pointer fetch, and indirect with Y added after it. Each mode has a read, a store and a read-modify-write form. The block fetches the instruction's address bytes and, where a mode needs them, the page-zero pointer bytes. It also issues the filler reads the mode calls for. A read adds a cycle only when indexing carries into the high address byte. Stores and read-modify-write always take the longer path.

The block captures the fetched operand, pulses done in the last bus cycle and reports the program counter that follows the operand bytes. The modify step of read-modify-write is a stand-in: it adds one to the value or subtracts one from it, as selected by an input.

Top module: `opnd_addr_seq`

## Requirements
- R1: Reset is synchronous and active-low (`rst_n`=0). While in reset and afterwards in idle, `rw` is 1 (read) and `done` is 0, and a start pulse given during reset is not acted on.
- R2: `start` is accepted only in idle. The first operand bus cycle is the cycle after the accepting edge and reads address `pc_in`. Mode, class, modify select, X and Y are latched at acceptance. A start given while a sequence runs has no effect on that sequence.
- R3: Mode codes: 0 immediate, 1 zero page, 2 zero page+X, 3 zero page+Y, 4 absolute, 5 absolute+X, 6 absolute+Y, 7 indirect pre-indexed by X, 8 indirect post-indexed by Y. Every page-zero access has high byte 00. The page-zero index sum drops its carry. The indexed zero-page modes read the unindexed base {00,base} once before the indexed access.
- R4: Immediate reads one byte at `pc_in` (1 cycle). Zero page reads the address byte and then accesses {00,ADL} (2 cycles). Absolute reads the low byte and then the high byte and then accesses {ADH,ADL} (3 cycles).
- R5: An absolute-indexed read first accesses {BAH, BAL+index}. If BAL+index does not carry, that access ends the read (3 cycles). If it carries, that data is dropped and one more read at {BAH+1, BAL+index} ends it (4 cycles).
- R6: Pre-indexed indirect does a filler read at {00,base}, reads the pointer low byte at {00,base+X} and the high byte at {00,base+X+1} (wrapping in page zero), then accesses the pointed address (5 cycles for read or store).
- R7: Post-indexed indirect reads the base low and high bytes at {00,IAL} and {00,IAL+1}, then adds Y with the same page-cross rule as R5 (read: 4 cycles, or 5 on a carry).
- R8: Operation class codes: 0 read, 1 store, 2 read-modify-write. A store ends in one write cycle (`rw`=0) that drives `st_data`. Indexed stores never shorten: absolute-indexed and post-indexed stores always do the filler read at the uncarried address and then write (4 and 5 cycles).
- R9: Read-modify-write reads the operand, writes the same value back in the next cycle, and then writes the modified value (+1 when `mod_dec`=0, −1 when `mod_dec`=1), all three at one address.
- R10: `done` is high for exactly the final bus cycle of a sequence. From the next cycle, `opnd` holds the byte read in the final read access (for read-modify-write, the unmodified value) until a new capture.
- R11: From the cycle after acceptance, `pc_next` equals `pc_in`+2 for the absolute modes (4, 5, 6) and `pc_in`+1 for all others, and holds while the sequence runs.
- R12: Mode codes 9–15 behave as immediate. Class code 3 behaves as read. Immediate ignores the class and always reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operand sequence (accepted in idle) |
| mode | input | 4 | Addressing mode code |
| op_class | input | 2 | Operation class code |
| mod_dec | input | 1 | Modify select: 0 increment, 1 decrement |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| pc_in | input | 16 | Address of the first operand byte |
| rdata | input | 8 | Read data bus, valid in the cycle of the address |
| st_data | input | 8 | Register value written by stores |
| addr | output | 16 | Address bus |
| rw | output | 1 | 1 read, 0 write |
| wdata | output | 8 | Write data, valid when rw is 0 |
| opnd | output | 8 | Captured operand |
| done | output | 1 | High in the final bus cycle |
| pc_next | output | 16 | Program counter past the operand bytes |

## Verification
The first operand address is due one cycle after the edge that accepts `start`. Each later bus cycle follows one clock after the one before, and `done` is due in the final bus cycle. `pc_next` is due from that first cycle, and `opnd` is due from the cycle after `done`. The bench drives inputs and samples outputs on falling edges. It steps through each expected trace one clock at a time, comparing address, strobe, write data and `done` in every slot, so a missing or extra filler cycle shows as a misaligned address or an early or late `done`. It then checks `opnd` and `pc_next` in the first idle cycle.

// File: rtl/oas_pkg.sv
// Package: shared types and small mode helpers of the operand address sequencer.
// Assumes an 8-bit data path where a page is one data-byte of address.
package oas_pkg;

    typedef enum logic [3:0] {
        M_IMM  = 4'd0,
        M_ZP   = 4'd1,
        M_ZPX  = 4'd2,
        M_ZPY  = 4'd3,
        M_ABS  = 4'd4,
        M_ABSX = 4'd5,
        M_ABSY = 4'd6,
        M_INDX = 4'd7,
        M_INDY = 4'd8
    } amode_e;

    typedef enum logic [1:0] {
        C_READ  = 2'd0,
        C_STORE = 2'd1,
        C_RMW   = 2'd2
    } opcls_e;

    // One phase per bus cycle.
    typedef enum logic [3:0] {
        P_IDLE,
        P_OPR0,    // first operand byte at pc
        P_OPR1,    // second operand byte at pc+1
        P_ZPDUM,   // filler read at unindexed page-zero base
        P_PTRL,    // pointer low byte in page zero
        P_PTRH,    // pointer high byte in page zero
        P_IDXTRY,  // indexed access with uncorrected high byte
        P_ACC,     // effective-address access
        P_WBACK,   // write back the unmodified value
        P_WMOD     // write the modified value
    } phase_e;

    // Modes whose index is Y.
    function automatic logic uses_y(input amode_e m);
        return (m == M_ZPY) || (m == M_ABSY) || (m == M_INDY);
    endfunction

    // Modes that carry a two-byte address in the instruction.
    function automatic logic two_byte(input amode_e m);
        return (m == M_ABS) || (m == M_ABSX) || (m == M_ABSY);
    endfunction

endpackage

// File: rtl/oas_modify.sv
// Module: oas_modify
// Stand-in for the modify step of read-modify-write: adds or subtracts one.
// Assumes the real operation unit replaces this later; purely combinational.
module oas_modify #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] din,
    input  logic          dec,
    output logic [DW-1:0] dout
);

    // Increment or decrement the captured operand.
    always_comb begin
        dout = dec ? (din - DW'(1)) : (din + DW'(1));
    end

endmodule

// File: rtl/oas_seq_ctrl.sv
// Module: oas_seq_ctrl
// Phase sequencer: accepts a start in idle, latches the normalised mode and
// class, and walks one phase per bus cycle until the operand access ends.
// Assumes the datapath reports the low-byte index carry for the current phase.
module oas_seq_ctrl
    import oas_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [3:0]  mode,
    input  logic [1:0]  op_class,
    input  logic        mod_dec,
    input  logic        carry,
    output phase_e      phase,
    output amode_e      mode_n,
    output amode_e      mode_q,
    output opcls_e      cls_q,
    output logic        dec_q,
    output logic        accept,
    output logic        done
);

    opcls_e cls_n;
    phase_e phase_d;

    // Map unused mode codes to immediate; immediate and class 3 read.
    always_comb begin
        mode_n = (mode > 4'd8) ? M_IMM : amode_e'(mode);
        if (mode_n == M_IMM || op_class == 2'd3) cls_n = C_READ;
        else                                     cls_n = opcls_e'(op_class);
        accept = start && (phase == P_IDLE);
    end

    // Next phase and end-of-sequence decode.
    always_comb begin
        phase_d = phase;
        done    = 1'b0;
        unique case (phase)
            P_IDLE:   if (start) phase_d = P_OPR0;
            P_OPR0: begin
                unique case (mode_q)
                    M_IMM:                begin phase_d = P_IDLE; done = 1'b1; end
                    M_ZP:                 phase_d = P_ACC;
                    M_ZPX, M_ZPY, M_INDX: phase_d = P_ZPDUM;
                    M_INDY:               phase_d = P_PTRL;
                    default:              phase_d = P_OPR1;
                endcase
            end
            P_OPR1:   phase_d = (mode_q == M_ABS) ? P_ACC : P_IDXTRY;
            P_ZPDUM:  phase_d = (mode_q == M_INDX) ? P_PTRL : P_ACC;
            P_PTRL:   phase_d = P_PTRH;
            P_PTRH:   phase_d = (mode_q == M_INDX) ? P_ACC : P_IDXTRY;
            P_IDXTRY: begin
                if (cls_q == C_READ && !carry) begin
                    phase_d = P_IDLE;
                    done    = 1'b1;
                end else begin
                    phase_d = P_ACC;
                end
            end
            P_ACC: begin
                if (cls_q == C_RMW) begin
                    phase_d = P_WBACK;
                end else begin
                    phase_d = P_IDLE;
                    done    = 1'b1;
                end
            end
            P_WBACK:  phase_d = P_WMOD;
            P_WMOD:   begin phase_d = P_IDLE; done = 1'b1; end
            default:  phase_d = P_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= P_IDLE;
        else        phase <= phase_d;
    end

    // Latch the sequence parameters when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_IMM;
            cls_q  <= C_READ;
            dec_q  <= 1'b0;
        end else if (accept) begin
            mode_q <= mode_n;
            cls_q  <= cls_n;
            dec_q  <= mod_dec;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != P_IDLE) |=> ($stable(mode_q) && $stable(cls_q) && phase != P_OPR0));  // R2
    AST_STORE_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_IDXTRY && cls_q == C_STORE) |=> (phase == P_ACC));  // R8
    AST_CROSS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_ACC && cls_q == C_READ && $past(phase) == P_IDXTRY) |-> $past(carry));  // R5

endmodule

// File: rtl/oas_addr_path.sv
// Module: oas_addr_path
// Address datapath: holds the program counter, the address bytes, the
// page-zero pointer and the captured operand, and selects the bus address,
// strobe and write data for the current phase.
// Assumes rdata is valid in the same cycle as the address that selects it.
module oas_addr_path
    import oas_pkg::*;
#(
    parameter  int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  phase_e        phase,
    input  amode_e        mode_n,
    input  amode_e        mode_q,
    input  opcls_e        cls_q,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] st_data,
    input  logic [DW-1:0] mod_val,
    output logic [AW-1:0] addr,
    output logic          rw,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] opnd,
    output logic [AW-1:0] pc_next,
    output logic          carry,
    output logic [DW-1:0] dat_q
);

    localparam logic [DW-1:0] PAGE0 = '0;

    logic [AW-1:0] pc_q;
    logic [DW-1:0] lo_q, hi_q, ptr_q, x_q, y_q, idx_sel;
    logic [DW:0]   sum;

    // Index selection and low-byte sum with carry out.
    always_comb begin
        idx_sel = uses_y(mode_q) ? y_q : x_q;
        sum     = {1'b0, lo_q} + {1'b0, idx_sel};
        carry   = sum[DW];
    end

    // Capture the program counter, indices and next-PC at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q     <= '0;
            y_q     <= '0;
            pc_next <= '0;
        end else if (accept) begin
            x_q     <= idx_x;
            y_q     <= idx_y;
            pc_next <= pc_in + (two_byte(mode_n) ? AW'(2) : AW'(1));
        end
    end

    // Address byte, pointer and operand registers, updated per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            ptr_q <= '0;
            dat_q <= '0;
            opnd  <= '0;
        end else begin
            unique case (phase)
                P_IDLE: if (accept) pc_q <= pc_in;
                P_OPR0: begin
                    lo_q  <= rdata;
                    ptr_q <= rdata;
                    hi_q  <= PAGE0;
                    pc_q  <= pc_q + AW'(1);
                    if (mode_q == M_IMM) opnd <= rdata;
                end
                P_OPR1:  hi_q <= rdata;
                P_ZPDUM: begin
                    if (mode_q == M_INDX) ptr_q <= sum[DW-1:0];
                    else                  lo_q  <= sum[DW-1:0];
                end
                P_PTRL: begin
                    lo_q  <= rdata;
                    ptr_q <= ptr_q + DW'(1);
                end
                P_PTRH:  hi_q <= rdata;
                P_IDXTRY: begin
                    lo_q <= sum[DW-1:0];
                    hi_q <= hi_q + DW'(carry);
                    if (cls_q == C_READ && !carry) opnd <= rdata;
                end
                P_ACC: begin
                    if (cls_q != C_STORE) begin
                        opnd  <= rdata;
                        dat_q <= rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // Bus address, strobe and write data for the current phase.
    always_comb begin
        rw    = 1'b1;
        wdata = dat_q;
        unique case (phase)
            P_IDLE, P_OPR0, P_OPR1: addr = pc_q;
            P_ZPDUM:                addr = {PAGE0, lo_q};
            P_PTRL, P_PTRH:         addr = {PAGE0, ptr_q};
            P_IDXTRY:               addr = {hi_q, sum[DW-1:0]};
            P_ACC: begin
                addr = {hi_q, lo_q};
                if (cls_q == C_STORE) begin
                    rw    = 1'b0;
                    wdata = st_data;
                end
            end
            P_WBACK: begin
                addr = {hi_q, lo_q};
                rw   = 1'b0;
            end
            P_WMOD: begin
                addr  = {hi_q, lo_q};
                rw    = 1'b0;
                wdata = mod_val;
            end
            default: addr = pc_q;
        endcase
    end

    AST_ZP_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_ZPDUM) |-> (rw && addr[AW-1:DW] == PAGE0 && addr[DW-1:0] == $past(rdata)));  // R3
    AST_PTR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_PTRH) |-> (addr[AW-1:DW] == PAGE0 && addr[DW-1:0] == $past(addr[DW-1:0]) + DW'(1)));  // R6
    AST_PAGE_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_ACC && $past(phase) == P_IDXTRY) |->
        (addr == {$past(addr[AW-1:DW]) + DW'($past(carry)), $past(addr[DW-1:0])}));  // R5
    AST_RMW_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == P_WMOD) |-> (addr == $past(addr) && !$past(rw) &&
        (wdata == $past(wdata) + DW'(1) || wdata == $past(wdata) - DW'(1))));  // R9
    AST_PCN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != P_IDLE) |=> $stable(pc_next));  // R11

endmodule

// File: rtl/opnd_addr_seq.sv
// Module: opnd_addr_seq
// Top of the operand address sequencer: joins the phase sequencer, the
// address datapath and the modify stand-in.
// Assumes the caller holds st_data stable while a store runs.
module opnd_addr_seq
    import oas_pkg::*;
#(
    parameter  int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [1:0]    op_class,
    input  logic          mod_dec,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] st_data,
    output logic [AW-1:0] addr,
    output logic          rw,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] opnd,
    output logic          done,
    output logic [AW-1:0] pc_next
);

    phase_e        phase;
    amode_e        mode_n, mode_q;
    opcls_e        cls_q;
    logic          dec_q, accept, carry;
    logic [DW-1:0] dat_q, mod_val;

    oas_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .op_class (op_class),
        .mod_dec  (mod_dec),
        .carry    (carry),
        .phase    (phase),
        .mode_n   (mode_n),
        .mode_q   (mode_q),
        .cls_q    (cls_q),
        .dec_q    (dec_q),
        .accept   (accept),
        .done     (done)
    );

    oas_addr_path #(.DW(DW)) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .phase   (phase),
        .mode_n  (mode_n),
        .mode_q  (mode_q),
        .cls_q   (cls_q),
        .pc_in   (pc_in),
        .idx_x   (idx_x),
        .idx_y   (idx_y),
        .rdata   (rdata),
        .st_data (st_data),
        .mod_val (mod_val),
        .addr    (addr),
        .rw      (rw),
        .wdata   (wdata),
        .opnd    (opnd),
        .pc_next (pc_next),
        .carry   (carry),
        .dat_q   (dat_q)
    );

    oas_modify #(.DW(DW)) u_mod (
        .din  (dat_q),
        .dec  (dec_q),
        .dout (mod_val)
    );

    AST_FIRST_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rw && addr == $past(pc_in)));  // R2
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (rw && !done));  // R1

endmodule

// File: tb/sim_opnd_addr_seq.sv
// Bench: walks a table of expected bus traces, then directed reset and
// start-while-busy tests. Memory content is a pure function of the address.
module sim_opnd_addr_seq;

    typedef struct packed {
        logic [3:0]        req;
        logic [3:0]        mode;
        logic [1:0]        cls;
        logic              dec;
        logic [7:0]        x;
        logic [7:0]        y;
        logic [15:0]       pc;
        logic [2:0]        len;
        logic [0:6]        wr;
        logic [0:6][15:0]  a;
        logic              chk_op;
        logic [7:0]        opnd;
        logic [7:0]        wfirst;
        logic [7:0]        wlast;
        logic [15:0]       pcn;
    } vec_t;

    localparam int NV = 22;
    localparam logic [7:0] ST = 8'hA5;

    localparam vec_t VECS [NV] = '{
        // R4 immediate read
        '{4'd4, 4'd0, 2'd0, 1'b0, 8'h00, 8'h00, 16'h1000, 3'd1, 7'b0000000,
          '{16'h1000, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h10, 8'h00, 8'h00, 16'h1001},
        // R4 zero page read
        '{4'd4, 4'd1, 2'd0, 1'b0, 8'h00, 8'h00, 16'h1100, 3'd2, 7'b0000000,
          '{16'h1100, 16'h0011, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h11, 8'h00, 8'h00, 16'h1101},
        // R8 zero page store
        '{4'd8, 4'd1, 2'd1, 1'b0, 8'h00, 8'h00, 16'h1200, 3'd2, 7'b0100000,
          '{16'h1200, 16'h0012, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b0, 8'h00, ST, ST, 16'h1201},
        // R9 zero page read-modify-write, increment
        '{4'd9, 4'd1, 2'd2, 1'b0, 8'h00, 8'h00, 16'h1300, 3'd4, 7'b0011000,
          '{16'h1300, 16'h0013, 16'h0013, 16'h0013, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h13, 8'h13, 8'h14, 16'h1301},
        // R4 absolute read, R11 pc+2
        '{4'd4, 4'd4, 2'd0, 1'b0, 8'h00, 8'h00, 16'h2000, 3'd3, 7'b0000000,
          '{16'h2000, 16'h2001, 16'h2120, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h01, 8'h00, 8'h00, 16'h2002},
        // R8 absolute store
        '{4'd8, 4'd4, 2'd1, 1'b0, 8'h00, 8'h00, 16'h2000, 3'd3, 7'b0010000,
          '{16'h2000, 16'h2001, 16'h2120, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b0, 8'h00, ST, ST, 16'h2002},
        // R3 zero page+X read, sum wraps in page zero
        '{4'd3, 4'd2, 2'd0, 1'b0, 8'hF0, 8'h00, 16'h1400, 3'd3, 7'b0000000,
          '{16'h1400, 16'h0014, 16'h0004, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h04, 8'h00, 8'h00, 16'h1401},
        // R3 zero page+Y store
        '{4'd3, 4'd3, 2'd1, 1'b0, 8'h00, 8'h03, 16'h1500, 3'd3, 7'b0010000,
          '{16'h1500, 16'h0015, 16'h0018, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b0, 8'h00, ST, ST, 16'h1501},
        // R9 zero page+X read-modify-write
        '{4'd9, 4'd2, 2'd2, 1'b0, 8'h01, 8'h00, 16'h1400, 3'd5, 7'b0001100,
          '{16'h1400, 16'h0014, 16'h0015, 16'h0015, 16'h0015, 16'h0, 16'h0}, 1'b1, 8'h15, 8'h15, 8'h16, 16'h1401},
        // R5 absolute+X read, no carry
        '{4'd5, 4'd5, 2'd0, 1'b0, 8'h02, 8'h00, 16'h3000, 3'd3, 7'b0000000,
          '{16'h3000, 16'h3001, 16'h3132, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h03, 8'h00, 8'h00, 16'h3002},
        // R5 absolute+X read, carry adds a cycle
        '{4'd5, 4'd5, 2'd0, 1'b0, 8'hE0, 8'h00, 16'h3000, 3'd4, 7'b0000000,
          '{16'h3000, 16'h3001, 16'h3110, 16'h3210, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h22, 8'h00, 8'h00, 16'h3002},
        // R8 absolute+Y store, no carry still long
        '{4'd8, 4'd6, 2'd1, 1'b0, 8'h00, 8'h01, 16'h3000, 3'd4, 7'b0001000,
          '{16'h3000, 16'h3001, 16'h3131, 16'h3131, 16'h0, 16'h0, 16'h0}, 1'b0, 8'h00, ST, ST, 16'h3002},
        // R9 absolute+X read-modify-write with carry, decrement
        '{4'd9, 4'd5, 2'd2, 1'b1, 8'hE0, 8'h00, 16'h3000, 3'd6, 7'b0000110,
          '{16'h3000, 16'h3001, 16'h3110, 16'h3210, 16'h3210, 16'h3210, 16'h0}, 1'b1, 8'h22, 8'h22, 8'h21, 16'h3002},
        // R6 pre-indexed indirect read
        '{4'd6, 4'd7, 2'd0, 1'b0, 8'h04, 8'h00, 16'h1600, 3'd5, 7'b0000000,
          '{16'h1600, 16'h0016, 16'h001A, 16'h001B, 16'h1B1A, 16'h0, 16'h0}, 1'b1, 8'h01, 8'h00, 8'h00, 16'h1601},
        // R6 pre-indexed indirect, pointer high byte wraps to 0000
        '{4'd6, 4'd7, 2'd0, 1'b0, 8'hE9, 8'h00, 16'h1600, 3'd5, 7'b0000000,
          '{16'h1600, 16'h0016, 16'h00FF, 16'h0000, 16'h00FF, 16'h0, 16'h0}, 1'b1, 8'hFF, 8'h00, 8'h00, 16'h1601},
        // R7 post-indexed indirect read, no carry
        '{4'd7, 4'd8, 2'd0, 1'b0, 8'h00, 8'h10, 16'h1700, 3'd4, 7'b0000000,
          '{16'h1700, 16'h0017, 16'h0018, 16'h1827, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h3F, 8'h00, 8'h00, 16'h1701},
        // R7 post-indexed indirect read, carry
        '{4'd7, 4'd8, 2'd0, 1'b0, 8'h00, 8'hF0, 16'h1700, 3'd5, 7'b0000000,
          '{16'h1700, 16'h0017, 16'h0018, 16'h1807, 16'h1907, 16'h0, 16'h0}, 1'b1, 8'h1E, 8'h00, 8'h00, 16'h1701},
        // R8 post-indexed indirect store
        '{4'd8, 4'd8, 2'd1, 1'b0, 8'h00, 8'h10, 16'h1700, 3'd5, 7'b0000100,
          '{16'h1700, 16'h0017, 16'h0018, 16'h1827, 16'h1827, 16'h0, 16'h0}, 1'b0, 8'h00, ST, ST, 16'h1701},
        // R9 pre-indexed indirect read-modify-write, decrement
        '{4'd9, 4'd7, 2'd2, 1'b1, 8'h04, 8'h00, 16'h1600, 3'd7, 7'b0000011,
          '{16'h1600, 16'h0016, 16'h001A, 16'h001B, 16'h1B1A, 16'h1B1A, 16'h1B1A}, 1'b1, 8'h01, 8'h01, 8'h00, 16'h1601},
        // R12 unused mode code acts as immediate
        '{4'd12, 4'd12, 2'd0, 1'b0, 8'h00, 8'h00, 16'h1800, 3'd1, 7'b0000000,
          '{16'h1800, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h18, 8'h00, 8'h00, 16'h1801},
        // R12 immediate with store class still reads
        '{4'd12, 4'd0, 2'd1, 1'b0, 8'h00, 8'h00, 16'h1900, 3'd1, 7'b0000000,
          '{16'h1900, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h19, 8'h00, 8'h00, 16'h1901},
        // R12 class code 3 acts as read
        '{4'd12, 4'd1, 2'd3, 1'b0, 8'h00, 8'h00, 16'h1100, 3'd2, 7'b0000000,
          '{16'h1100, 16'h0011, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 8'h11, 8'h00, 8'h00, 16'h1101}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  op_class = '0;
    logic        mod_dec = 1'b0;
    logic [7:0]  idx_x = '0, idx_y = '0, st_data = ST;
    logic [15:0] pc_in = '0;
    logic [7:0]  rdata, wdata, opnd;
    logic [15:0] addr, pc_next;
    logic        rw, done;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    // Memory model: byte at an address is the XOR of its two halves.
    assign rdata = addr[7:0] ^ addr[15:8];

    opnd_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_class(op_class),
        .mod_dec(mod_dec), .idx_x(idx_x), .idx_y(idx_y), .pc_in(pc_in), .rdata(rdata),
        .st_data(st_data), .addr(addr), .rw(rw), .wdata(wdata), .opnd(opnd),
        .done(done), .pc_next(pc_next)
    );

    task automatic chk(input int req, input int vi, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL R%0d vec %0d %s: actual %h expected %h", req, vi, what, act, exp);
        end
    endtask

    // Run one table vector; with hold set, start stays high and the
    // mode, pc and index inputs change while the sequence runs.
    task automatic run_vec(input vec_t v, input int vi, input bit hold);
        @(negedge clk);
        mode = v.mode; op_class = v.cls; mod_dec = v.dec;
        idx_x = v.x; idx_y = v.y; pc_in = v.pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (hold) begin
            mode = 4'd0; op_class = 2'd1; mod_dec = ~v.dec;
            idx_x = ~v.x; idx_y = ~v.y; pc_in = 16'h0;
        end
        for (int s = 0; s < 7; s++) begin
            if (s < int'(v.len)) begin
                start = hold && (s < int'(v.len) - 1);
                chk(int'(v.req), vi, $sformatf("addr slot %0d", s), addr, v.a[s]);
                chk(int'(v.req), vi, $sformatf("rw slot %0d", s), {15'd0, rw}, {15'd0, ~v.wr[s]});
                chk(10, vi, $sformatf("done slot %0d", s), {15'd0, done},
                    {15'd0, (s == int'(v.len) - 1)});
                if (v.wr[s])
                    chk(int'(v.req), vi, $sformatf("wdata slot %0d", s), {8'd0, wdata},
                        {8'd0, (s == int'(v.len) - 1) ? v.wlast : v.wfirst});
                if (s == 0) chk(11, vi, "pc_next", pc_next, v.pcn);
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(10, vi, "done after end", {15'd0, done}, 16'd0);
        chk(1, vi, "idle rw", {15'd0, rw}, 16'd1);
        chk(11, vi, "pc_next held", pc_next, v.pcn);
        if (v.chk_op) chk(10, vi, "opnd", {8'd0, opnd}, {8'd0, v.opnd});
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset state, and a start held during reset is not acted on
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk(1, -1, "reset rw", {15'd0, rw}, 16'd1);
        chk(1, -1, "reset done", {15'd0, done}, 16'd0);
        rst_n = 1'b1; start = 1'b0;
        @(negedge clk);
        chk(1, -1, "post-reset rw", {15'd0, rw}, 16'd1);
        chk(1, -1, "post-reset done", {15'd0, done}, 16'd0);

        // Table walk
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i, 1'b0);

        // R2: start held and inputs changed during a running sequence
        run_vec(VECS[13], 100, 1'b1);
        run_vec(VECS[12], 101, 1'b1);

        // R1: reset in the middle of a sequence returns to idle
        @(negedge clk);
        mode = 4'd5; op_class = 2'd2; idx_x = 8'hE0; pc_in = 16'h3000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, 102, "mid reset rw", {15'd0, rw}, 16'd1);
        chk(1, 102, "mid reset done", {15'd0, done}, 16'd0);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(1, 102, "idle after reset rw", {15'd0, rw}, 16'd1);
            chk(1, 102, "idle after reset done", {15'd0, done}, 16'd0);
        end
        run_vec(VECS[1], 103, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule